// File: doc/BRIEF.md
# T1 Transmit Channel Timing Generator

This block produces the per-channel timing strobes for the transmit side of a T1 serial framer running at 1.544 Mb/s. It tracks the bit position inside a 193-bit frame: one framing bit followed by 24 channels of 8 bits each, sent MSB first. From that position it drives three outputs. The first is a channel clock that pulses on the last (least significant) bit of every channel. The second is a per-channel block signal taken from a 24-bit mask. The third is a link-data demand clock. That clock runs at 4 kHz normally and at 2 kHz when the zero-byte time-slot-interchange link mode is selected.

A one-cycle frame-sync pulse aligns the counter to the framing slot. Without further syncs the counter wraps every 193 bits. The mask presented at the input is captured only at frame boundaries, so a mid-frame update never truncates a channel's block window. The block also returns a copy of the NRZ serial input, captured on the falling edge of the bit clock.

Top module: `t1tx_chan_timer`

## Requirements
- R1: `chan_clk` is high for exactly one bit time, on the eighth (LSB) bit of each channel. Counting the framing bit as position 0, these are frame positions 8, 16, ..., 192, which gives 24 pulses per frame.
- R2: During the framing-bit slot (position 0), `chan_clk` and `chan_blk` are both low.
- R3: At frame position p in 1..192, `chan_blk` equals bit (p-1)/8 of the active mask. Mask bit 0 belongs to the first channel after the framing bit, and bit 23 to the last.
- R4: The active mask is loaded from `chan_mask` at each frame boundary, meaning the edge that enters the framing slot. A change of `chan_mask` in mid-frame has no effect on `chan_blk` until the next frame.
- R5: With `zbtsi_mode` = 0, `link_clk` is high for the framing slot of every second frame, starting with the frame entered by the first sync after reset.
- R6: With `zbtsi_mode` = 1, `link_clk` is high for the framing slot of every fourth frame, in the same frame numbering as R5.
- R7: `frame_sync` high at a rising edge puts the counter into the framing slot for the next bit time, from any position. Without sync, the framing slot recurs every 193 bit times.
- R8: `ser_q` takes the value of `ser_in` at each falling edge of `clk`.
- R9: While reset is low, and after reset until the first `frame_sync`, `chan_clk`, `chan_blk` and `link_clk` stay low. The active mask is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse aligning the counter to the framing slot |
| chan_mask | input | 24 | Per-channel block pattern, bit 0 = first channel |
| zbtsi_mode | input | 1 | 1 selects the half-rate link demand clock |
| ser_in | input | 1 | NRZ transmit serial data |
| chan_clk | output | 1 | Channel LSB strobe |
| chan_blk | output | 1 | Masked per-channel block output |
| link_clk | output | 1 | Link-data demand clock |
| ser_q | output | 1 | Serial data captured on the falling clock edge |

## Verification
The bench attacks the frame wrap at position 192. An off-by-one there would shift every channel strobe by a bit, or put a strobe into the framing slot. It also changes the mask in mid-frame, which a design loading the mask without waiting for the boundary would show as a truncated or extended block window. Syncs are placed early inside a frame and repeated back to back, which catches a counter that ignores them or that miscounts link frames after re-alignment. The link mode is switched between runs so that a wrong divide ratio or phase appears in the framing slots.

// File: rtl/t1tx_pkg.sv
`timescale 1ns/1ps
// Shared constants for the T1 transmit channel timing generator.
// Assumes a frame of one framing bit followed by CHANNELS * CHAN_BITS bits.
package t1tx_pkg;
    localparam int T1_CHANNELS  = 24;
    localparam int T1_CHAN_BITS = 8;
    localparam int LINK_DIV_W   = 2;   // frame counter width for link clock
endpackage

// File: rtl/t1tx_bit_counter.sv
`timescale 1ns/1ps
// Bit position tracker: framing slot flag, channel index, bit-in-channel index.
// Assumes frame_sync is a single-cycle pulse; waits idle until the first one.
module t1tx_bit_counter #(
    parameter int NCHAN  = 24,
    parameter int CHBITS = 8,
    localparam int CHW   = $clog2(NCHAN),
    localparam int BTW   = $clog2(CHBITS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_sync,
    output logic           synced,
    output logic           fbit,
    output logic [CHW-1:0] ch,
    output logic [BTW-1:0] bt,
    output logic           boundary
);
    localparam logic [CHW-1:0] CH_LAST = CHW'(NCHAN - 1);
    localparam logic [BTW-1:0] BT_LAST = BTW'(CHBITS - 1);

    logic last_bit;

    // Marks the final bit of the final channel.
    always_comb begin
        last_bit = synced && !fbit && (ch == CH_LAST) && (bt == BT_LAST);
        boundary = frame_sync || last_bit;
    end

    // Advances the position each bit time, realigns on sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced <= 1'b0;
            fbit   <= 1'b1;
            ch     <= '0;
            bt     <= '0;
        end else if (frame_sync) begin
            synced <= 1'b1;
            fbit   <= 1'b1;
            ch     <= '0;
            bt     <= '0;
        end else if (synced) begin
            if (fbit) begin
                fbit <= 1'b0;
                ch   <= '0;
                bt   <= '0;
            end else if (bt == BT_LAST) begin
                bt <= '0;
                if (ch == CH_LAST) begin
                    fbit <= 1'b1;
                end else begin
                    ch <= ch + 1'b1;
                end
            end else begin
                bt <= bt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/t1tx_chan_strobe.sv
`timescale 1ns/1ps
// Channel strobes: LSB clock and masked block output.
// Assumes the mask input may change at any time; it is captured at boundaries only.
module t1tx_chan_strobe #(
    parameter int NCHAN  = 24,
    parameter int CHBITS = 8,
    localparam int CHW   = $clog2(NCHAN),
    localparam int BTW   = $clog2(CHBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             synced,
    input  logic             fbit,
    input  logic [CHW-1:0]   ch,
    input  logic [BTW-1:0]   bt,
    input  logic             boundary,
    input  logic [NCHAN-1:0] mask_in,
    output logic             chan_clk,
    output logic             chan_blk
);
    localparam logic [BTW-1:0] BT_LAST = BTW'(CHBITS - 1);

    logic [NCHAN-1:0] act_mask;
    logic             in_chan;

    // Loads the working mask when entering the framing slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mask <= '0;
        end else if (boundary) begin
            act_mask <= mask_in;
        end
    end

    // Decodes the strobes from the current position.
    always_comb begin
        in_chan  = synced && !fbit;
        chan_clk = in_chan && (bt == BT_LAST);
        chan_blk = in_chan && act_mask[ch];
    end
endmodule

// File: rtl/t1tx_link_clk.sv
`timescale 1ns/1ps
// Link demand clock: counts frames and strobes in selected framing slots.
// Assumes boundary pulses on every edge entering the framing slot.
module t1tx_link_clk #(
    parameter int FCW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic synced,
    input  logic fbit,
    input  logic boundary,
    input  logic zbtsi_mode,
    output logic link_clk
);
    logic [FCW-1:0] fcnt;

    // Counts frames; the first sync after reset starts at frame zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (boundary) begin
            fcnt <= synced ? fcnt + 1'b1 : '0;
        end
    end

    // Selects every 2nd or every 4th framing slot.
    always_comb begin
        if (zbtsi_mode) begin
            link_clk = synced && fbit && (fcnt[1:0] == 2'd0);
        end else begin
            link_clk = synced && fbit && !fcnt[0];
        end
    end
endmodule

// File: rtl/t1tx_chan_timer.sv
`timescale 1ns/1ps
// Top of the T1 transmit channel timing generator.
// Assumes a single bit clock domain; serial data captured on its falling edge.
module t1tx_chan_timer
    import t1tx_pkg::*;
#(
    parameter int NCHAN  = T1_CHANNELS,
    parameter int CHBITS = T1_CHAN_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic [NCHAN-1:0] chan_mask,
    input  logic             zbtsi_mode,
    input  logic             ser_in,
    output logic             chan_clk,
    output logic             chan_blk,
    output logic             link_clk,
    output logic             ser_q
);
    localparam int CHW = $clog2(NCHAN);
    localparam int BTW = $clog2(CHBITS);

    logic           synced;
    logic           fbit;
    logic [CHW-1:0] ch;
    logic [BTW-1:0] bt;
    logic           boundary;

    t1tx_bit_counter #(.NCHAN(NCHAN), .CHBITS(CHBITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .synced(synced), .fbit(fbit), .ch(ch), .bt(bt), .boundary(boundary)
    );

    t1tx_chan_strobe #(.NCHAN(NCHAN), .CHBITS(CHBITS)) u_strobe (
        .clk(clk), .rst_n(rst_n), .synced(synced), .fbit(fbit),
        .ch(ch), .bt(bt), .boundary(boundary), .mask_in(chan_mask),
        .chan_clk(chan_clk), .chan_blk(chan_blk)
    );

    t1tx_link_clk #(.FCW(LINK_DIV_W)) u_link (
        .clk(clk), .rst_n(rst_n), .synced(synced), .fbit(fbit),
        .boundary(boundary), .zbtsi_mode(zbtsi_mode), .link_clk(link_clk)
    );

    // Captures serial data on the falling edge of the bit clock.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ser_q <= 1'b0;
        end else begin
            ser_q <= ser_in;
        end
    end
endmodule

// File: rtl/t1tx_chan_timer_chk.sv
`timescale 1ns/1ps
// Port-level property checker for t1tx_chan_timer.
module t1tx_chan_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_sync,
    input logic chan_clk,
    input logic chan_blk,
    input logic link_clk
);
    logic seen_sync;

    // Remembers whether a sync has arrived since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_sync <= 1'b0;
        else if (frame_sync) seen_sync <= 1'b1;
    end

    AST_CHCLK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk |=> !chan_clk); // R1
    AST_FRAMING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        link_clk |-> (!chan_clk && !chan_blk)); // R2
    AST_LINK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        link_clk |=> !link_clk); // R5
    AST_SYNC_TO_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (!chan_clk && !chan_blk)); // R7
    AST_IDLE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync |-> (!chan_clk && !chan_blk && !link_clk)); // R9
endmodule

bind t1tx_chan_timer t1tx_chan_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .chan_clk(chan_clk), .chan_blk(chan_blk), .link_clk(link_clk)
);

// File: tb/test_t1tx_chan_timer.sv
`timescale 1ns/1ps
module test_t1tx_chan_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic [23:0] chan_mask = '0;
    logic        zbtsi_mode = 1'b0;
    logic        ser_in = 1'b0;
    logic        chan_clk, chan_blk, link_clk, ser_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    bit          m_synced = 0;
    int          m_pos = 0;
    int          m_fcnt = 0;
    logic [23:0] m_mask = '0;

    always #5 clk = ~clk;

    t1tx_chan_timer i_t1tx_chan_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .chan_mask(chan_mask),
        .zbtsi_mode(zbtsi_mode), .ser_in(ser_in), .chan_clk(chan_clk),
        .chan_blk(chan_blk), .link_clk(link_clk), .ser_q(ser_q)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %b expected %b (pos %0d)", req, $time, act, exp, m_pos);
        end
    endtask

    function automatic bit exp_chclk();
        return m_synced && m_pos != 0 && (m_pos % 8) == 0;
    endfunction
    function automatic bit exp_blk();
        return m_synced && m_pos != 0 && m_mask[(m_pos - 1) / 8];
    endfunction
    function automatic bit exp_link();
        if (!m_synced || m_pos != 0) return 0;
        return zbtsi_mode ? (m_fcnt % 4 == 0) : (m_fcnt % 2 == 0);
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_synced = 0; m_pos = 0; m_fcnt = 0; m_mask = '0;
        end else if (frame_sync) begin
            m_fcnt = m_synced ? m_fcnt + 1 : 0;
            m_synced = 1; m_pos = 0; m_mask = chan_mask;
        end else if (m_synced) begin
            if (m_pos == 192) begin
                m_pos = 0; m_fcnt++; m_mask = chan_mask;
            end else begin
                m_pos++;
            end
        end
    endtask

    // One bit time: model the edge, drive new inputs, compare after the falling edge.
    task automatic step(input logic r, input logic fs, input logic [23:0] m, input logic z);
        @(posedge clk);
        model_edge();
        #2;
        rst_n = r; frame_sync = fs; chan_mask = m; zbtsi_mode = z;
        ser_in = 1'($urandom);
        #5;
        if (!m_synced) begin
            check("R9", chan_clk, 1'b0);
            check("R9", chan_blk, 1'b0);
            check("R9", link_clk, 1'b0);
        end else if (m_pos == 0) begin
            check("R2", chan_clk, 1'b0);
            check("R2", chan_blk, 1'b0);
            check(zbtsi_mode ? "R6" : "R5", link_clk, exp_link());
        end else begin
            check("R1", chan_clk, exp_chclk());
            check("R3", chan_blk, exp_blk());
            check("R5", link_clk, 1'b0);
        end
        check("R8", ser_q, rst_n ? ser_in : 1'b0);
    endtask

    initial begin
        logic [23:0] m;
        logic        z;
        void'($urandom(32'd7405));
        // R9: reset held, then idle without sync
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 24'hFFFFFF, 1'b0);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 24'hFFFFFF, 1'b0);
        // R7: first sync; all-ones mask, then all-zeros mid-frame (R4)
        step(1'b1, 1'b1, 24'hFFFFFF, 1'b0);
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 24'hFFFFFF, 1'b0);
        for (int i = 0; i < 500; i++) step(1'b1, 1'b0, 24'h000000, 1'b0);
        // R7: early sync inside a frame and back-to-back syncs
        step(1'b1, 1'b1, 24'hA5A5A5, 1'b0);
        step(1'b1, 1'b1, 24'hA5A5A5, 1'b0);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 24'h5A5A5A, 1'b0);
        step(1'b1, 1'b1, 24'h5A5A5A, 1'b0);
        // R5 / R4 random: normal link rate, random mid-frame mask updates
        m = 24'($urandom);
        for (int i = 0; i < 2500; i++) begin
            if ($urandom_range(0, 99) == 0) m = 24'($urandom);
            step(1'b1, $urandom_range(0, 799) == 0, m, 1'b0);
        end
        // R6 random: half-rate link clock
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) == 0) m = 24'($urandom);
            step(1'b1, $urandom_range(0, 799) == 0, m, 1'b1);
        end
        // R5/R6: mode toggles between frames
        z = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 299) == 0) z = ~z;
            step(1'b1, 1'b0, m, z);
        end
        // R9: reset mid-run clears mask and sync state
        step(1'b0, 1'b0, 24'hFFFFFF, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 24'hFFFFFF, 1'b0);
        step(1'b1, 1'b1, 24'h000001, 1'b0);
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0, 24'h800000, 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule